// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This block sits beside the page write controller of a byte-wide non-volatile memory. It watches every accepted write byte (address and data) and looks for two fixed key sequences. A three-byte sequence arms write protection. A six-byte sequence disarms it. The protection flag itself only moves at the end of the write period that follows a completed sequence. The flag is not touched by the ordinary synchronous reset. Only a separate factory-initialisation input, or a completed key sequence, can change it.

Each byte that matches the next expected step of a key sequence is flagged as a command byte in the same cycle, so the page buffer does not store it. Once a full sequence has been accepted, the rest of the load is ordinary data. While protection is on, the block drives a commit-enable level to the page write controller. The controller samples it when the load window closes. A load that was not preceded by a complete sequence still runs the busy timer in the controller, but it commits nothing to the array. When protection is off, commit is always allowed.

The key steps are: step 0 = data 0xAA at address 0x1555, step 1 = 0x55 at 0x0AAA, then either 0xA0 at 0x1555 (arm), or 0x80 at 0x1555 followed by 0xAA at 0x1555, 0x55 at 0x0AAA and 0x20 at 0x1555 (disarm).

Top module: `wp_cmd_guard`

## Requirements
- R1: After the bytes 0xAA@0x1555, 0x55@0x0AAA, 0xA0@0x1555 in one load, `prot_on` goes to 1 in the cycle after the next `write_done` pulse. Before that pulse it keeps its old value.
- R2: After the six bytes 0xAA@0x1555, 0x55@0x0AAA, 0x80@0x1555, 0xAA@0x1555, 0x55@0x0AAA, 0x20@0x1555 in one load, `prot_on` goes to 0 in the cycle after the next `write_done` pulse.
- R3: `cmd_byte` is 1, in the same cycle as `wr_stb`, for each byte that matches the next expected key step, including the final byte of a sequence. It is 0 for data bytes that follow a completed sequence in the same load, and it is never 1 without `wr_stb`.
- R4: A byte that does not match the next expected step (wrong address or wrong data) returns the detector to idle and gets `cmd_byte` = 0. The later bytes of the broken sequence are then not recognised.
- R5: A `load_timeout` pulse aborts a partially entered sequence. Bytes entered after it are not recognised as its continuation.
- R6: `commit_en` is 1 whenever `prot_on` is 0. While `prot_on` is 1, it is 1 only once a full arm or disarm sequence has been accepted in the current load, and 0 otherwise.
- R7: `rst` leaves `prot_on` unchanged. It clears a partial sequence and any completed-but-not-yet-applied sequence.
- R8: `factory_init` sets `prot_on` to 0 in the next cycle and discards any pending sequence.
- R9: An arm sequence followed by no data bytes still takes effect at the following `write_done`.
- R10: `prot_on` does not change on a `write_done` that was not preceded by a completed sequence, nor in any cycle without `write_done` or `factory_init`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (does not affect the protection flag) |
| factory_init | input | 1 | Forces the protection flag off and clears all sequence state |
| wr_stb | input | 1 | One-cycle strobe for an accepted write byte |
| wr_addr | input | ADDR_W | Address of the write byte |
| wr_data | input | DATA_W | Data of the write byte |
| load_timeout | input | 1 | Byte-load window expired; the current load closes |
| write_done | input | 1 | End of the internal write period |
| prot_on | output | 1 | Protection flag |
| cmd_byte | output | 1 | Current byte is a key-sequence byte and must not be stored |
| commit_en | output | 1 | Current load may be committed to the array |

## Verification
The bench attacks the timing of the flag. An arm sequence with no trailing data, and a check of `prot_on` between sequence completion and `write_done`, catch a design that applies the change early or needs a data byte to apply it. A reset or factory pulse between a completed sequence and its `write_done` catches a design that leaves a stale pending action behind. The same reset pulse shows whether reset wrongly clears the flag itself. Broken sequences (wrong data, wrong address, a load timeout in the middle) catch a matcher that resumes where it left off, and a locked load without a key catches a commit gate that lets unauthorised data through.

// File: rtl/wp_cmd_pkg.sv
`timescale 1ns/1ps
package wp_cmd_pkg;

    localparam int KEY_ADDR_W = 13;
    localparam int KEY_DATA_W = 8;
    localparam int N_PAT      = 7;

    localparam logic [KEY_ADDR_W-1:0] KEY_ADDR_HI = 13'h1555;
    localparam logic [KEY_ADDR_W-1:0] KEY_ADDR_LO = 13'h0AAA;

    // Matcher position inside a key sequence
    typedef enum logic [2:0] {
        M_IDLE   = 3'd0,
        M_K1     = 3'd1,
        M_K2     = 3'd2,
        M_D3     = 3'd3,
        M_D4     = 3'd4,
        M_D5     = 3'd5,
        M_ARM_OK = 3'd6,
        M_DIS_OK = 3'd7
    } match_st_t;

    // Flag action waiting for the end of the write period
    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_SET  = 2'd1,
        PEND_CLR  = 2'd2
    } pend_t;

    // Events from the matcher to the flag keeper
    typedef struct packed {
        logic arm_hit;
        logic dis_hit;
        logic authorised;
    } seq_evt_t;

    // Pattern index: 0 AA@HI, 1 55@LO, 2 A0@HI, 3 80@HI, 4 AA@HI, 5 55@LO, 6 20@HI
    function automatic logic [KEY_ADDR_W-1:0] pat_addr(input int idx);
        return (idx == 1 || idx == 5) ? KEY_ADDR_LO : KEY_ADDR_HI;
    endfunction

    function automatic logic [KEY_DATA_W-1:0] pat_data(input int idx);
        case (idx)
            0, 4:    return 8'hAA;
            1, 5:    return 8'h55;
            2:       return 8'hA0;
            3:       return 8'h80;
            default: return 8'h20;
        endcase
    endfunction

endpackage

// File: rtl/wp_key_match.sv
`timescale 1ns/1ps
module wp_key_match
    import wp_cmd_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_timeout,
    output logic              cmd_byte,
    output seq_evt_t          evt
);

    logic [N_PAT-1:0] hit;

    generate
        for (genvar g = 0; g < N_PAT; g++) begin : g_pat
            assign hit[g] = (wr_addr == ADDR_W'(pat_addr(g))) &&
                            (wr_data == DATA_W'(pat_data(g)));
        end
    endgenerate

    match_st_t st_q, st_d;
    logic      step_ok;

    always_comb begin
        st_d    = st_q;
        step_ok = 1'b0;
        if (wr_stb) begin
            case (st_q)
                M_IDLE: step_ok = hit[0];
                M_K1:   step_ok = hit[1];
                M_K2:   step_ok = hit[2] || hit[3];
                M_D3:   step_ok = hit[4];
                M_D4:   step_ok = hit[5];
                M_D5:   step_ok = hit[6];
                default: step_ok = 1'b0;
            endcase
            case (st_q)
                M_ARM_OK, M_DIS_OK: st_d = st_q;
                default: begin
                    if (!step_ok) begin
                        st_d = M_IDLE;
                    end else begin
                        case (st_q)
                            M_IDLE:  st_d = M_K1;
                            M_K1:    st_d = M_K2;
                            M_K2:    st_d = hit[2] ? M_ARM_OK : M_D3;
                            M_D3:    st_d = M_D4;
                            M_D4:    st_d = M_D5;
                            default: st_d = M_DIS_OK;
                        endcase
                    end
                end
            endcase
        end
        if (load_timeout) begin
            st_d = M_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            st_q <= M_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_byte       = step_ok;
    assign evt.arm_hit    = wr_stb && (st_q == M_K2) && hit[2];
    assign evt.dis_hit    = wr_stb && (st_q == M_D5) && hit[6];
    assign evt.authorised = (st_q == M_ARM_OK) || (st_q == M_DIS_OK);

endmodule

// File: rtl/wp_flag_keep.sv
`timescale 1ns/1ps
module wp_flag_keep
    import wp_cmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     factory_init,
    input  logic     write_done,
    input  seq_evt_t evt,
    output logic     prot_on
);

    pend_t pend_q;
    logic  flag_q;

    // The flag has no link to rst: only factory_init or a finished sequence moves it
    always_ff @(posedge clk) begin
        if (factory_init) begin
            flag_q <= 1'b0;
        end else if (!rst && write_done) begin
            case (pend_q)
                PEND_SET: flag_q <= 1'b1;
                PEND_CLR: flag_q <= 1'b0;
                default:  flag_q <= flag_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (factory_init || rst) begin
            pend_q <= PEND_NONE;
        end else if (write_done) begin
            pend_q <= PEND_NONE;
        end else if (evt.arm_hit) begin
            pend_q <= PEND_SET;
        end else if (evt.dis_hit) begin
            pend_q <= PEND_CLR;
        end
    end

    assign prot_on = flag_q;

endmodule

// File: rtl/wp_cmd_guard.sv
`timescale 1ns/1ps
module wp_cmd_guard
    import wp_cmd_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              factory_init,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_timeout,
    input  logic              write_done,
    output logic              prot_on,
    output logic              cmd_byte,
    output logic              commit_en
);

    seq_evt_t evt;
    logic     match_clr;

    assign match_clr = rst || factory_init;

    wp_key_match #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_match (
        .clk          (clk),
        .clr          (match_clr),
        .wr_stb       (wr_stb),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .load_timeout (load_timeout),
        .cmd_byte     (cmd_byte),
        .evt          (evt)
    );

    wp_flag_keep u_flag (
        .clk          (clk),
        .rst          (rst),
        .factory_init (factory_init),
        .write_done   (write_done),
        .evt          (evt),
        .prot_on      (prot_on)
    );

    assign commit_en = !prot_on || evt.authorised;

endmodule

// File: rtl/wp_cmd_guard_chk.sv
`timescale 1ns/1ps
module wp_cmd_guard_chk (
    input logic clk,
    input logic rst,
    input logic factory_init,
    input logic wr_stb,
    input logic write_done,
    input logic prot_on,
    input logic cmd_byte,
    input logic commit_en
);

    p_cmd_needs_stb_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_byte |-> wr_stb);

    p_off_commits_r6: assert property (@(posedge clk) disable iff (rst || factory_init)
        !prot_on |-> commit_en);

    p_reset_keeps_flag_r7: assert property (@(posedge clk) disable iff (factory_init)
        rst |=> $stable(prot_on));

    p_factory_clears_r8: assert property (@(posedge clk)
        factory_init |=> !prot_on);

    p_flag_moves_on_done_r10: assert property (@(posedge clk) disable iff (rst)
        (!write_done && !factory_init) |=> $stable(prot_on));

endmodule

bind wp_cmd_guard wp_cmd_guard_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .factory_init (factory_init),
    .wr_stb       (wr_stb),
    .write_done   (write_done),
    .prot_on      (prot_on),
    .cmd_byte     (cmd_byte),
    .commit_en    (commit_en)
);

// File: tb/test_wp_cmd_guard.sv
`timescale 1ns/1ps
module test_wp_cmd_guard;

    logic        clk = 1'b0;
    logic        rst, factory_init, wr_stb, load_timeout, write_done;
    logic [12:0] wr_addr;
    logic [7:0]  wr_data;
    logic        prot_on, cmd_byte, commit_en;

    int checks = 0;
    int fails  = 0;
    bit run_over = 1'b0;

    // Expected-item scoreboard: signal selector, value, tag
    int    sel_q[$];
    bit    exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    wp_cmd_guard i_wp_cmd_guard (
        .clk          (clk),
        .rst          (rst),
        .factory_init (factory_init),
        .wr_stb       (wr_stb),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .load_timeout (load_timeout),
        .write_done   (write_done),
        .prot_on      (prot_on),
        .cmd_byte     (cmd_byte),
        .commit_en    (commit_en)
    );

    task automatic push_exp(input int sel, input bit v, input string tag);
        sel_q.push_back(sel);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic drive(input bit stb, input logic [12:0] a, input logic [7:0] d,
                         input bit tmo, input bit dn, input bit r, input bit fi);
        @(negedge clk);
        wr_stb       = stb;
        wr_addr      = a;
        wr_data      = d;
        load_timeout = tmo;
        write_done   = dn;
        rst          = r;
        factory_init = fi;
    endtask

    task automatic wbyte(input logic [12:0] a, input logic [7:0] d,
                         input bit exp_cmd, input string tag);
        drive(1'b1, a, d, 1'b0, 1'b0, 1'b0, 1'b0);
        push_exp(0, exp_cmd, tag);
    endtask

    task automatic close_load(input bit exp_commit, input string tag);
        drive(1'b0, '0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
        push_exp(1, exp_commit, tag);
    endtask

    task automatic finish_write();
        drive(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic pulse_rst();
        drive(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic pulse_factory();
        drive(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic idle_prot(input bit v, input string tag);
        drive(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        push_exp(2, v, tag);
    endtask

    task automatic idle_commit(input bit v, input string tag);
        drive(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        push_exp(1, v, tag);
    endtask

    task automatic arm_seq(input string tag);
        wbyte(13'h1555, 8'hAA, 1'b1, tag);
        wbyte(13'h0AAA, 8'h55, 1'b1, tag);
        wbyte(13'h1555, 8'hA0, 1'b1, tag);
    endtask

    task automatic disarm_seq(input string tag);
        wbyte(13'h1555, 8'hAA, 1'b1, tag);
        wbyte(13'h0AAA, 8'h55, 1'b1, tag);
        wbyte(13'h1555, 8'h80, 1'b1, tag);
        wbyte(13'h1555, 8'hAA, 1'b1, tag);
        wbyte(13'h0AAA, 8'h55, 1'b1, tag);
        wbyte(13'h1555, 8'h20, 1'b1, tag);
    endtask

    // Monitor: compare every queued expectation away from the clock edge
    always begin
        @(negedge clk);
        #1;
        while (sel_q.size() > 0) begin
            int    sel;
            bit    ev;
            string tg;
            logic  act;
            sel = sel_q.pop_front();
            ev  = exp_q.pop_front();
            tg  = tag_q.pop_front();
            act = (sel == 0) ? cmd_byte : (sel == 1) ? commit_en : prot_on;
            checks++;
            if (act !== ev) begin
                fails++;
                $display("FAIL %s: %s actual %b expected %b", tg,
                         (sel == 0) ? "cmd_byte" : (sel == 1) ? "commit_en" : "prot_on",
                         act, ev);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!run_over) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; factory_init = 1'b1; wr_stb = 1'b0; load_timeout = 1'b0;
        write_done = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);

        // Reset state
        idle_prot(1'b0, "R8 flag off after factory init");
        idle_commit(1'b1, "R6 commit allowed when unprotected");
        wbyte(13'h0040, 8'h12, 1'b0, "R3 plain byte is not a command");
        close_load(1'b1, "R6 unprotected load commits");
        finish_write();
        idle_prot(1'b0, "R10 plain write leaves flag off");

        // Arm with trailing data
        arm_seq("R3 arm byte flagged");
        wbyte(13'h0100, 8'h33, 1'b0, "R3 data after arm not flagged");
        idle_prot(1'b0, "R1 flag unchanged before write end");
        close_load(1'b1, "R6 commit during arm load");
        finish_write();
        idle_prot(1'b1, "R1 flag set at write end");

        // Locked plain load
        wbyte(13'h0200, 8'h44, 1'b0, "R3 plain byte while locked");
        idle_commit(1'b0, "R6 no commit without key");
        close_load(1'b0, "R6 locked load blocked at close");
        finish_write();
        idle_prot(1'b1, "R10 plain write keeps flag on");

        // Keyed write while locked
        arm_seq("R3 keyed write prefix");
        wbyte(13'h1555, 8'h99, 1'b0, "R3 user data at key address");
        close_load(1'b1, "R6 keyed load commits while locked");
        finish_write();
        idle_prot(1'b1, "R1 re-arm keeps flag on");

        // Reset keeps flag, clears partial sequence
        wbyte(13'h1555, 8'hAA, 1'b1, "R3 first key byte");
        wbyte(13'h0AAA, 8'h55, 1'b1, "R3 second key byte");
        pulse_rst();
        idle_prot(1'b1, "R7 reset keeps flag");
        wbyte(13'h1555, 8'hA0, 1'b0, "R7 partial sequence cleared by reset");
        close_load(1'b0, "R7 no authorisation after reset");
        finish_write();

        // Mismatch by data
        wbyte(13'h1555, 8'hAA, 1'b1, "R4 start");
        wbyte(13'h0AAA, 8'h56, 1'b0, "R4 wrong data not flagged");
        wbyte(13'h1555, 8'hA0, 1'b0, "R4 continuation not recognised");
        close_load(1'b0, "R4 broken sequence does not authorise");
        finish_write();
        // Mismatch by address
        wbyte(13'h1555, 8'hAA, 1'b1, "R4 start again");
        wbyte(13'h0AAB, 8'h55, 1'b0, "R4 wrong address not flagged");
        close_load(1'b0, "R4 no commit after wrong address");
        finish_write();
        idle_prot(1'b1, "R10 flag still on after broken sequences");

        // Timeout aborts
        wbyte(13'h1555, 8'hAA, 1'b1, "R5 start");
        wbyte(13'h0AAA, 8'h55, 1'b1, "R5 second");
        close_load(1'b0, "R5 partial key does not authorise");
        wbyte(13'h1555, 8'hA0, 1'b0, "R5 aborted sequence not resumed");
        close_load(1'b0, "R5 still locked");
        finish_write();

        // Disarm
        disarm_seq("R2 disarm byte flagged");
        idle_prot(1'b1, "R2 flag unchanged before write end");
        idle_commit(1'b1, "R6 authorised after disarm");
        close_load(1'b1, "R6 disarm load commits");
        finish_write();
        idle_prot(1'b0, "R2 flag cleared at write end");

        // Arm without data
        arm_seq("R9 bare arm");
        close_load(1'b1, "R9 bare arm load");
        finish_write();
        idle_prot(1'b1, "R9 flag set without data bytes");

        // Reset drops a pending disarm
        disarm_seq("R7 disarm before reset");
        pulse_rst();
        finish_write();
        idle_prot(1'b1, "R7 pending disarm discarded by reset");

        // Factory init
        pulse_factory();
        idle_prot(1'b0, "R8 factory init clears flag");
        arm_seq("R8 arm before factory init");
        pulse_factory();
        finish_write();
        idle_prot(1'b0, "R8 pending arm discarded");
        idle_commit(1'b1, "R6 unlocked after factory init");

        drive(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        #3;
        run_over = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule